// File: doc/BRIEF.md
# Translation Fault Classifier with Refill Register Update

This block sits directly behind the translation lookaside buffer of a 32-bit core. Each cycle in which a request is presented, it combines the virtual address, the access direction, the current privilege and error-level state, and the result code of the TLB lookup. From these it decides whether the access faults and, if so, which exception code applies. A privilege check on the address segment runs first. A user-mode access to the upper half of the address space faults without regard to what the lookup reported.

When a fault is raised, the block also forms the new values of three coprocessor registers: the bad virtual address, the page-table context pointer and the entry-high register. It presents them to the register file together with one write strobe for each. The register file supplies the current context and entry-high values, so the fields that must survive a fault are carried across. Results come out one clock after the request. Exception dispatch and pipeline flushing take place elsewhere.

Top module: `mmu_fault_top`

## Requirements
- R1: While reset is held, and in the first cycle after reset ends, `excValid`, `refillMiss`, all three write strobes, `excCode` and all three value outputs are 0.
- R2: If `userMode` is 1 and `vaddr[31]` is 1, the request faults whatever `tlbResult` and `errLevel` hold. The code is 5 (address error on store) when `isWrite` is 1 and 4 (address error on load) when it is 0, and `refillMiss` is 0.
- R3: A request that is not under R2, with `vaddr[31]`=0 and `errLevel`=0, is mapped. A mapped request with `tlbResult`=1 (no matching entry) faults with code 3 on a write and code 2 on a read, and `refillMiss` is 1.
- R4: A mapped request with `tlbResult`=2 (entry matched but not valid) faults with code 3 on a write and code 2 on a read, and `refillMiss` is 0.
- R5: A mapped request with `tlbResult`=3 (entry matched but not writable) faults with code 1 in either direction, and `refillMiss` is 0.
- R6: A mapped request with `tlbResult`=0 (hit) raises no fault. Every output is 0 in the next cycle.
- R7: A request with `errLevel`=1 and `vaddr[31]`=0 raises no fault, whatever `tlbResult` holds.
- R8: A request with `userMode`=0 and `vaddr[31]`=1 raises no fault, whatever `tlbResult` holds.
- R9: On every fault, `badVaddrWe` is 1 and `badVaddrNext` equals the full faulting address.
- R10: On every fault, `contextWe` is 1 and `contextNext` = (curContext & 0xFF800000) | ((vaddr >> 9) & 0x007FFFF0).
- R11: On every fault, `entryHiWe` is 1 and `entryHiNext` = (curEntryHi & 0x000000FF) | (vaddr & 0xFFFFE000).
- R12: All outputs reflect the request of the previous clock only. A cycle without `reqValid`, and every non-faulting request, gives all-zero outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| vaddr | input | 32 | Virtual address of the access |
| isWrite | input | 1 | 1 for a store, 0 for a load or fetch |
| userMode | input | 1 | Core runs in user mode |
| errLevel | input | 1 | Error level set: lower half of the address space is unmapped |
| tlbResult | input | 2 | Lookup result: 0 hit, 1 no match, 2 not valid, 3 not writable |
| curContext | input | 32 | Current context register value |
| curEntryHi | input | 32 | Current entry-high register value |
| excValid | output | 1 | A fault was raised for the previous request |
| excCode | output | 5 | Exception code of the fault |
| refillMiss | output | 1 | The fault is a refill miss (no matching entry) |
| badVaddrWe | output | 1 | Write strobe for the bad-address register |
| badVaddrNext | output | 32 | New bad-address value |
| contextWe | output | 1 | Write strobe for the context register |
| contextNext | output | 32 | New context value |
| entryHiWe | output | 1 | Write strobe for the entry-high register |
| entryHiNext | output | 32 | New entry-high value |

## Verification
The segment privilege check and the lookup-result decode can both apply to the same request. This happens when a user-mode access to the upper half arrives together with a failing lookup code, and possibly with the error level set as well. The bench drives these overlaps on purpose, for example a user store to 0xC0001000 with the not-writable code and the error level raised. It then expects the address-error code with the refill flag clear. A behavioural model ranks the privilege check above the lookup decode and is compared with the outputs on every clock. The model also covers long runs of random requests in which both conditions occur.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

  typedef enum logic [1:0] {
    TLB_HIT     = 2'd0,
    TLB_MISS    = 2'd1,
    TLB_INVALID = 2'd2,
    TLB_RDONLY  = 2'd3
  } tlbRes_e;

  typedef enum logic [4:0] {
    EXC_NONE = 5'd0,
    EXC_MOD  = 5'd1,
    EXC_TLBL = 5'd2,
    EXC_TLBS = 5'd3,
    EXC_ADEL = 5'd4,
    EXC_ADES = 5'd5
  } excCode_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic loadBadVa;
    logic loadCtx;
    logic loadEntryHi;
  } regStb_t;

endpackage

// File: rtl/mmu_fault_ctrl.sv
module mmu_fault_ctrl
  import mmu_fault_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     vaddrHi,
  input  logic     isWrite,
  input  logic     userMode,
  input  logic     errLevel,
  input  tlbRes_e  tlbResult,
  output regStb_t  regStb,
  output logic     excValid,
  output excCode_e excCode,
  output logic     refillMiss
);

  logic     privFault;
  logic     mappedReq;
  logic     faultNow;
  logic     refillNow;
  excCode_e codeNow;

  // segment privilege check comes before the lookup decode
  assign privFault = userMode && vaddrHi;
  assign mappedReq = !vaddrHi && !errLevel;

  always_comb begin
    faultNow  = 1'b0;
    refillNow = 1'b0;
    codeNow   = EXC_NONE;
    if (reqValid) begin
      if (privFault) begin
        faultNow = 1'b1;
        codeNow  = isWrite ? EXC_ADES : EXC_ADEL;
      end else if (mappedReq) begin
        unique case (tlbResult)
          TLB_MISS: begin
            faultNow  = 1'b1;
            refillNow = 1'b1;
            codeNow   = isWrite ? EXC_TLBS : EXC_TLBL;
          end
          TLB_INVALID: begin
            faultNow = 1'b1;
            codeNow  = isWrite ? EXC_TLBS : EXC_TLBL;
          end
          TLB_RDONLY: begin
            faultNow = 1'b1;
            codeNow  = EXC_MOD;
          end
          default: begin
            faultNow = 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    regStb.loadBadVa   = faultNow;
    regStb.loadCtx     = faultNow;
    regStb.loadEntryHi = faultNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid   <= 1'b0;
      excCode    <= EXC_NONE;
      refillMiss <= 1'b0;
    end else begin
      excValid   <= faultNow;
      excCode    <= codeNow;
      refillMiss <= refillNow;
    end
  end

endmodule

// File: rtl/mmu_fault_dp.sv
module mmu_fault_dp
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  parameter int PTE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           regStb,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] curContext,
  input  logic [ADDR_W-1:0] curEntryHi,
  output logic              badVaddrWe,
  output logic [ADDR_W-1:0] badVaddrNext,
  output logic              contextWe,
  output logic [ADDR_W-1:0] contextNext,
  output logic              entryHiWe,
  output logic [ADDR_W-1:0] entryHiNext
);

  // a page pair is mapped by one entry: the VPN2 field drops the page-select bit
  localparam int VPN2_LSB = PAGE_BITS + 1;
  localparam int VPN2_W   = ADDR_W - VPN2_LSB;
  localparam int CTX_BASE = PTE_SHIFT + VPN2_W;
  localparam int EH_GAP   = VPN2_LSB - ASID_W;

  logic [VPN2_W-1:0]  vpn2;
  logic [ADDR_W-1:0]  ctxFormed;
  logic [ADDR_W-1:0]  ehFormed;

  assign vpn2 = vaddr[ADDR_W-1:VPN2_LSB];

  generate
    if (CTX_BASE < ADDR_W) begin : g_ctxBase
      assign ctxFormed = {curContext[ADDR_W-1:CTX_BASE], vpn2, {PTE_SHIFT{1'b0}}};
    end else begin : g_ctxNoBase
      assign ctxFormed = {vpn2, {PTE_SHIFT{1'b0}}};
    end
  endgenerate

  generate
    if (EH_GAP > 0) begin : g_ehGap
      assign ehFormed = {vpn2, {EH_GAP{1'b0}}, curEntryHi[ASID_W-1:0]};
    end else begin : g_ehNoGap
      assign ehFormed = {vpn2, curEntryHi[ASID_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badVaddrWe   <= 1'b0;
      badVaddrNext <= '0;
      contextWe    <= 1'b0;
      contextNext  <= '0;
      entryHiWe    <= 1'b0;
      entryHiNext  <= '0;
    end else begin
      badVaddrWe   <= regStb.loadBadVa;
      badVaddrNext <= regStb.loadBadVa ? vaddr : '0;
      contextWe    <= regStb.loadCtx;
      contextNext  <= regStb.loadCtx ? ctxFormed : '0;
      entryHiWe    <= regStb.loadEntryHi;
      entryHiNext  <= regStb.loadEntryHi ? ehFormed : '0;
    end
  end

endmodule

// File: rtl/mmu_fault_top.sv
module mmu_fault_top
  import mmu_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] vaddr,
  input  logic        isWrite,
  input  logic        userMode,
  input  logic        errLevel,
  input  logic [1:0]  tlbResult,
  input  logic [31:0] curContext,
  input  logic [31:0] curEntryHi,
  output logic        excValid,
  output logic [4:0]  excCode,
  output logic        refillMiss,
  output logic        badVaddrWe,
  output logic [31:0] badVaddrNext,
  output logic        contextWe,
  output logic [31:0] contextNext,
  output logic        entryHiWe,
  output logic [31:0] entryHiNext
);

  regStb_t  regStb;
  excCode_e codeInt;

  mmu_fault_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .vaddrHi    (vaddr[31]),
    .isWrite    (isWrite),
    .userMode   (userMode),
    .errLevel   (errLevel),
    .tlbResult  (tlbRes_e'(tlbResult)),
    .regStb     (regStb),
    .excValid   (excValid),
    .excCode    (codeInt),
    .refillMiss (refillMiss)
  );

  assign excCode = codeInt;

  mmu_fault_dp #(
    .ADDR_W    (32),
    .PAGE_BITS (12),
    .ASID_W    (8),
    .PTE_SHIFT (4)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .regStb       (regStb),
    .vaddr        (vaddr),
    .curContext   (curContext),
    .curEntryHi   (curEntryHi),
    .badVaddrWe   (badVaddrWe),
    .badVaddrNext (badVaddrNext),
    .contextWe    (contextWe),
    .contextNext  (contextNext),
    .entryHiWe    (entryHiWe),
    .entryHiNext  (entryHiNext)
  );

endmodule

// File: rtl/mmu_fault_chk.sv
module mmu_fault_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] vaddr,
  input logic        isWrite,
  input logic        userMode,
  input logic        errLevel,
  input logic [1:0]  tlbResult,
  input logic [31:0] curEntryHi,
  input logic        excValid,
  input logic [4:0]  excCode,
  input logic        refillMiss,
  input logic        badVaddrWe,
  input logic        contextWe,
  input logic        entryHiWe,
  input logic [31:0] entryHiNext
);

  assert_priv_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && userMode && vaddr[31]) |=>
      (excValid && !refillMiss && excCode == ($past(isWrite) ? 5'd5 : 5'd4)));

  assert_miss_refill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !vaddr[31] && !errLevel && tlbResult == 2'd1) |=>
      (excValid && refillMiss));

  assert_refill_implies_fault_R3: assert property (@(posedge clk) disable iff (!rstN)
    refillMiss |-> excValid);

  assert_errlevel_unmapped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && errLevel && !vaddr[31]) |=> !excValid);

  assert_strobes_with_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (badVaddrWe && contextWe && entryHiWe));

  assert_asid_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && userMode && vaddr[31]) |=>
      (entryHiNext[7:0] == $past(curEntryHi[7:0])));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!excValid && !badVaddrWe && !contextWe && !entryHiWe));

endmodule

bind mmu_fault_top mmu_fault_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .vaddr       (vaddr),
  .isWrite     (isWrite),
  .userMode    (userMode),
  .errLevel    (errLevel),
  .tlbResult   (tlbResult),
  .curEntryHi  (curEntryHi),
  .excValid    (excValid),
  .excCode     (excCode),
  .refillMiss  (refillMiss),
  .badVaddrWe  (badVaddrWe),
  .contextWe   (contextWe),
  .entryHiWe   (entryHiWe),
  .entryHiNext (entryHiNext)
);

// File: tb/mmu_fault_top_tb.sv
module mmu_fault_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic        userMode = 1'b0;
  logic        errLevel = 1'b0;
  logic [1:0]  tlbResult = '0;
  logic [31:0] curContext = '0;
  logic [31:0] curEntryHi = '0;
  logic        excValid, refillMiss, badVaddrWe, contextWe, entryHiWe;
  logic [4:0]  excCode;
  logic [31:0] badVaddrNext, contextNext, entryHiNext;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .isWrite(isWrite), .userMode(userMode), .errLevel(errLevel),
    .tlbResult(tlbResult), .curContext(curContext), .curEntryHi(curEntryHi),
    .excValid(excValid), .excCode(excCode), .refillMiss(refillMiss),
    .badVaddrWe(badVaddrWe), .badVaddrNext(badVaddrNext),
    .contextWe(contextWe), .contextNext(contextNext),
    .entryHiWe(entryHiWe), .entryHiNext(entryHiNext)
  );

  // expected outputs, built from the requirements for the previous request
  logic        expValid, expRefill;
  logic [4:0]  expCode;
  logic [31:0] expBad, expCtx, expEh;
  string       expTag;

  task automatic model(input logic rv, input logic [31:0] va, input logic wr,
                       input logic um, input logic el, input logic [1:0] tr,
                       input logic [31:0] ctx, input logic [31:0] eh);
    expValid = 0; expRefill = 0; expCode = 0;
    if (!rv) expTag = "R12";
    else if (um && va >= 32'h8000_0000) begin
      expTag = "R2"; expValid = 1; expCode = wr ? 5 : 4;
    end else if (va >= 32'h8000_0000) expTag = "R8";
    else if (el) expTag = "R7";
    else if (tr == 1) begin expTag = "R3"; expValid = 1; expRefill = 1; expCode = wr ? 3 : 2; end
    else if (tr == 2) begin expTag = "R4"; expValid = 1; expCode = wr ? 3 : 2; end
    else if (tr == 3) begin expTag = "R5"; expValid = 1; expCode = 1; end
    else expTag = "R6";
    expBad = expValid ? va : 0;
    expCtx = expValid ? ((ctx & 32'hFF80_0000) | ((va >> 9) & 32'h007F_FFF0)) : 0;
    expEh  = expValid ? ((eh & 32'h0000_00FF) | (va & 32'hFFFF_E000)) : 0;
  endtask

  task automatic check(input string tag, input logic ok, input logic [95:0] act,
                       input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check(expTag, {excValid, excCode, refillMiss} === {expValid, expCode, expRefill},
          {89'b0, excValid, excCode, refillMiss}, {89'b0, expValid, expCode, expRefill});
    check(expValid ? "R9" : expTag, {badVaddrWe, badVaddrNext} === {expValid, expBad},
          {63'b0, badVaddrWe, badVaddrNext}, {63'b0, expValid, expBad});
    check(expValid ? "R10" : expTag, {contextWe, contextNext} === {expValid, expCtx},
          {63'b0, contextWe, contextNext}, {63'b0, expValid, expCtx});
    check(expValid ? "R11" : expTag, {entryHiWe, entryHiNext} === {expValid, expEh},
          {63'b0, entryHiWe, entryHiNext}, {63'b0, expValid, expEh});
  endtask

  // drive at a falling edge, compare at the following falling edge
  task automatic step(input logic rv, input logic [31:0] va, input logic wr,
                      input logic um, input logic el, input logic [1:0] tr,
                      input logic [31:0] ctx, input logic [31:0] eh);
    reqValid = rv; vaddr = va; isWrite = wr; userMode = um; errLevel = el;
    tlbResult = tr; curContext = ctx; curEntryHi = eh;
    model(rv, va, wr, um, el, tr, ctx, eh);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet while reset is held, even with a faulting request present
    reqValid = 1; userMode = 1; vaddr = 32'hFFFF_0000;
    @(negedge clk);
    expValid = 0; expCode = 0; expRefill = 0; expBad = 0; expCtx = 0; expEh = 0;
    expTag = "R1";
    compareAll();
    reqValid = 0;
    rstN = 1;
    @(negedge clk);
    expTag = "R1";
    compareAll();

    // R2: privilege check wins over lookup code and error level
    step(1, 32'hC000_1000, 1, 1, 1, 2'd3, 32'h1234_5678, 32'hABCD_EF5A);
    step(1, 32'h8000_0004, 0, 1, 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R3: refill miss, both directions
    step(1, 32'h7FFF_E123, 1, 1, 0, 2'd1, 32'hA5A5_A5A5, 32'h0000_0011);
    step(1, 32'h0040_3FFC, 0, 0, 0, 2'd1, 32'h0000_0000, 32'h1234_56FF);
    // R4: invalid entry
    step(1, 32'h1000_2000, 1, 0, 0, 2'd2, 32'hFF80_0000, 32'h0000_1F42);
    step(1, 32'h1000_0FFF, 0, 1, 0, 2'd2, 32'h007F_FFFF, 32'h0000_0001);
    // R5: not writable, either direction
    step(1, 32'h2345_6789, 1, 0, 0, 2'd3, 32'h5555_5555, 32'hAAAA_AAAA);
    step(1, 32'h2345_6789, 0, 1, 0, 2'd3, 32'h5555_5555, 32'hAAAA_AAAA);
    // R6: hit
    step(1, 32'h0000_1000, 1, 1, 0, 2'd0, 32'h1111_1111, 32'h2222_2222);
    // R7: error level, useg unmapped
    step(1, 32'h0000_0000, 1, 0, 1, 2'd1, 32'h1111_1111, 32'h2222_2222);
    step(1, 32'h7FFF_FFFF, 0, 1, 1, 2'd3, 32'h1111_1111, 32'h2222_2222);
    // R8: kernel access to the upper half
    step(1, 32'hFFFF_FFFF, 1, 0, 0, 2'd1, 32'h1111_1111, 32'h2222_2222);
    step(1, 32'h8000_0000, 0, 0, 1, 2'd2, 32'h1111_1111, 32'h2222_2222);
    // R12: no request, faulting-looking inputs ignored; back-to-back faults
    step(0, 32'h0000_1000, 1, 0, 0, 2'd1, 32'h1111_1111, 32'h2222_2222);
    step(1, 32'h0000_2000, 1, 0, 0, 2'd1, 32'h1111_1111, 32'h2222_2222);
    step(1, 32'hE000_0000, 0, 1, 0, 2'd0, 32'h3333_3333, 32'h4444_4444);
    step(0, 32'hE000_0000, 0, 1, 0, 2'd0, 32'h3333_3333, 32'h4444_4444);

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom, 1'($urandom), 1'($urandom),
           $urandom_range(0, 3) == 0, 2'($urandom), $urandom, $urandom);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule